// File: doc/BRIEF.md
# Field Region Sequence Selector

This block follows the vertical position inside an image field and tells a downstream vertical pulse generator which programmed pattern to run. A field-start strobe clears a line counter. Each line strobe then advances the counter by one. Nine regions split the field by line number. Region 0 always starts at line 0. Each later region begins at a programmable start line. For the active region the block presents a pattern-select code and a sweep flag. The sweep flag tells the generator to let its pulse train run across line boundaries until the region ends.

The block also raises a flag for the whole of one programmable line, which is the line that carries the sensor transfer pulse. When the active region changes, the block gives a one-clock start strobe so the pattern generator can reload. Software loads the start lines, pattern selects, sweep bits and the transfer line through a simple write port. The start lines of regions 1 to 8 are expected to increase from one region to the next.

Top module: `vfield_region_sel`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold: `line_o` = 0, `region_o` = 0, `seq_sel_o` = 0, `sweep_o` = 0, `region_start_o` = 0. All configuration entries are 0, so `sg_line_o` is 1 because line 0 matches a transfer line of 0.
- R2: A clock with `vd` high sets both `line_o` and `region_o` to 0 at that edge. This holds even when `hd` is also high.
- R3: A clock with `hd` high and `vd` low increments `line_o` by one at that edge. Once the counter reaches its all-ones value it stays there.
- R4: When the line value produced by an `hd` edge equals the start line of region `region_o`+1, `region_o` increments by one at that same edge. It never moves by more than one region per edge.
- R5: `seq_sel_o` always equals the pattern-select entry of the active region.
- R6: `sweep_o` always equals the sweep bit of the active region.
- R7: `sg_line_o` is high exactly while `line_o` equals the transfer-line register.
- R8: `region_start_o` is high for exactly the one clock in which `region_o` first shows a new value. This includes a drop back to 0 caused by `vd`. It stays low when `vd` arrives while the region is already 0.
- R9: A region whose start line is never reached stops the advance. A start line of 0 is never reached by an `hd` edge. Region 8, once reached, holds until the next `vd`.
- R10: A write sets `cfg_we` high. `cfg_kind` selects the target: 0 is a start line (`cfg_idx` = region), 1 is a pattern select (low `SEQ_W` bits), 2 is a sweep bit (bit 0) and 3 is the transfer line (`cfg_idx` ignored). The new value takes effect on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vd | input | 1 | One-clock field-start strobe |
| hd | input | 1 | One-clock line strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_kind | input | 2 | Entry type: 0 start line, 1 pattern select, 2 sweep bit, 3 transfer line |
| cfg_idx | input | 4 | Region index of the entry |
| cfg_wdata | input | 12 | Write data |
| line_o | output | 12 | Current line within the field |
| region_o | output | 4 | Active region, 0 to 8 |
| seq_sel_o | output | 4 | Pattern select of the active region |
| sweep_o | output | 1 | Sweep flag of the active region |
| sg_line_o | output | 1 | High during the transfer line |
| region_start_o | output | 1 | One-clock strobe on a region change |

## Verification
The assertions are checked on every cycle. They cover these properties:
- the line counter clears on `vd`;
- it steps by exactly one on `hd`;
- the region only grows, by single steps, between field starts, and stays inside 0..8;
- every region change comes with the start strobe;
- a transfer-line write lands on the next clock.

Other properties need the bench's scenarios to show them. These include whether the region switches on exactly the programmed line, the pattern and sweep values shown for each region, a stall at an unreached start line, holding in region 8, and counter saturation.

// File: rtl/vfield_pkg.sv
// Package: shared types for the field region selector.
// Assumes nothing beyond standard SystemVerilog.
package vfield_pkg;
    // Which configuration entry a write targets.
    typedef enum logic [1:0] {
        CFG_START = 2'd0,
        CFG_SEQ   = 2'd1,
        CFG_SWEEP = 2'd2,
        CFG_XFER  = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/vfield_cfg_regs.sv
// Module: configuration store for start lines, pattern selects, sweep bits
// and the transfer line. Assumes writes are single-cycle with cfg_we high.
// Writes whose index is outside 0..NREG-1 store nothing.
module vfield_cfg_regs
    import vfield_pkg::*;
#(
    parameter int NREG   = 9,
    parameter int LINE_W = 12,
    parameter int SEQ_W  = 4,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_kind,
    input  logic [REG_W-1:0]               cfg_idx,
    input  logic [LINE_W-1:0]              cfg_wdata,
    output logic [NREG-1:0][LINE_W-1:0]    start_line,
    output logic [NREG-1:0][SEQ_W-1:0]     seq_sel,
    output logic [NREG-1:0]                sweep_en,
    output logic [LINE_W-1:0]              xfer_line
);
    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    // Per-region entries, one register set per region.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        // Store this region's entries when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_line[g] <= '0;
                seq_sel[g]    <= '0;
                sweep_en[g]   <= 1'b0;
            end else if (cfg_we && cfg_idx == REG_W'(g)) begin
                if (kind == CFG_START) start_line[g] <= cfg_wdata;
                if (kind == CFG_SEQ)   seq_sel[g]    <= cfg_wdata[SEQ_W-1:0];
                if (kind == CFG_SWEEP) sweep_en[g]   <= cfg_wdata[0];
            end
        end
    end

    // Store the transfer line; the index is not used for this entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                              xfer_line <= '0;
        else if (cfg_we && kind == CFG_XFER)     xfer_line <= cfg_wdata;
    end

    assert_xfer_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 2'd3) |=> (xfer_line == $past(cfg_wdata)));
endmodule

// File: rtl/vfield_line_counter.sv
// Module: line counter within a field. Assumes vd and hd are one-clock
// strobes; vd wins over hd. The counter saturates at all ones.
module vfield_line_counter #(
    parameter int LINE_W = 12,
    localparam logic [LINE_W-1:0] LINE_MAX = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd,
    input  logic              hd,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] line_next
);
    // Next line value from the strobes.
    always_comb begin
        if (vd)                            line_next = '0;
        else if (hd && line_q != LINE_MAX) line_next = line_q + 1'b1;
        else                               line_next = line_q;
    end

    // Register the line count.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_next;
    end

    assert_vd_clears_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vd |=> (line_q == '0));
    assert_hd_steps_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hd && !vd && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1));
endmodule

// File: rtl/vfield_region_tracker.sv
// Module: active-region tracker. Advances one region when the line value
// produced by an hd edge equals the next region's start line. Region 0 starts
// at line 0. Assumes start lines increase across regions. It also emits a
// one-clock strobe on every region change.
module vfield_region_tracker #(
    parameter int NREG   = 9,
    parameter int LINE_W = 12,
    localparam int REG_W = $clog2(NREG),
    localparam logic [REG_W-1:0] LAST = REG_W'(NREG - 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vd,
    input  logic                        hd,
    input  logic [LINE_W-1:0]           line_next,
    input  logic [NREG-1:0][LINE_W-1:0] start_line,
    output logic [REG_W-1:0]            region_q,
    output logic                        start_q
);
    logic             advance;
    logic [REG_W-1:0] region_next;

    // Decide whether the following region's start line is reached.
    always_comb begin
        advance = 1'b0;
        for (int i = 1; i < NREG; i++) begin
            if (REG_W'(i - 1) == region_q && line_next == start_line[i])
                advance = 1'b1;
        end
    end

    // Next region: field start returns to 0; an hd edge may step once.
    always_comb begin
        if (vd)                                   region_next = '0;
        else if (hd && advance && region_q != LAST) region_next = region_q + 1'b1;
        else                                      region_next = region_q;
    end

    // Register region and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= '0;
            start_q  <= 1'b0;
        end else begin
            region_q <= region_next;
            start_q  <= (region_next != region_q);
        end
    end

    assert_region_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vd |=> (region_q == $past(region_q) || region_q == $past(region_q) + 1'b1));
    assert_start_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region_q != $past(region_q)) |-> start_q);
    assert_region_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        region_q <= LAST);
endmodule

// File: rtl/vfield_region_sel.sv
// Module: top of the field region selector. Joins the configuration store,
// line counter and region tracker. It presents the active region's pattern
// select and sweep flag, plus a transfer-line flag. Assumes vd and hd are
// one-clock strobes synchronous to clk.
module vfield_region_sel #(
    parameter int NREG   = 9,
    parameter int LINE_W = 12,
    parameter int SEQ_W  = 4,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd,
    input  logic              hd,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [REG_W-1:0]  cfg_idx,
    input  logic [LINE_W-1:0] cfg_wdata,
    output logic [LINE_W-1:0] line_o,
    output logic [REG_W-1:0]  region_o,
    output logic [SEQ_W-1:0]  seq_sel_o,
    output logic              sweep_o,
    output logic              sg_line_o,
    output logic              region_start_o
);
    logic [NREG-1:0][LINE_W-1:0] start_line;
    logic [NREG-1:0][SEQ_W-1:0]  seq_sel;
    logic [NREG-1:0]             sweep_en;
    logic [LINE_W-1:0]           xfer_line;
    logic [LINE_W-1:0]           line_next;

    vfield_cfg_regs #(.NREG(NREG), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .start_line(start_line),
        .seq_sel(seq_sel), .sweep_en(sweep_en), .xfer_line(xfer_line)
    );

    vfield_line_counter #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd),
        .line_q(line_o), .line_next(line_next)
    );

    vfield_region_tracker #(.NREG(NREG), .LINE_W(LINE_W)) u_region (
        .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .line_next(line_next),
        .start_line(start_line), .region_q(region_o), .start_q(region_start_o)
    );

    // Present the active region's settings and the transfer-line flag.
    always_comb begin
        seq_sel_o = seq_sel[region_o];
        sweep_o   = sweep_en[region_o];
        sg_line_o = (line_o == xfer_line);
    end
endmodule

// File: tb/vfield_region_sel_tb.sv
module vfield_region_sel_tb;
    localparam int NREG = 9, LINE_W = 12, SEQ_W = 4, REG_W = 4;

    logic clk = 1'b0, rst_n = 1'b0, vd = 1'b0, hd = 1'b0, cfg_we = 1'b0;
    logic [1:0]        cfg_kind = '0;
    logic [REG_W-1:0]  cfg_idx = '0;
    logic [LINE_W-1:0] cfg_wdata = '0;
    logic [LINE_W-1:0] line_o;
    logic [REG_W-1:0]  region_o;
    logic [SEQ_W-1:0]  seq_sel_o;
    logic sweep_o, sg_line_o, region_start_o;

    int checks = 0, fails = 0;
    int m_line = 0, m_region = 0, m_start = 0, m_xfer = 0;
    int m_pos[NREG];
    int m_seq[NREG];
    int m_sw[NREG];

    always #2 clk = ~clk;

    vfield_region_sel u_dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " R3 line"}, int'(line_o), m_line);
        chk({tag, " R4 region"}, int'(region_o), m_region);
        chk({tag, " R5 seq"}, int'(seq_sel_o), m_seq[m_region]);
        chk({tag, " R6 sweep"}, int'(sweep_o), m_sw[m_region]);
        chk({tag, " R7 sg"}, int'(sg_line_o), int'(m_line == m_xfer));
        chk({tag, " R8 start"}, int'(region_start_o), m_start);
    endtask

    task automatic wr(int kind, int idx, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 4'(idx); cfg_wdata = 12'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 0) m_pos[idx] = data;
        if (kind == 1) m_seq[idx] = data % 16;
        if (kind == 2) m_sw[idx] = data % 2;
        if (kind == 3) m_xfer = data;
    endtask

    // One strobe cycle; the model follows the requirements.
    task automatic step(bit v, bit h);
        int old;
        @(negedge clk);
        vd = v; hd = h;
        @(negedge clk);
        vd = 1'b0; hd = 1'b0;
        old = m_region;
        if (v) begin
            m_line = 0; m_region = 0;
        end else if (h) begin
            if (m_line < 4095) m_line++;
            if (m_region < NREG - 1 && m_pos[m_region + 1] != 0 && m_line == m_pos[m_region + 1])
                m_region++;
        end
        m_start = int'(m_region != old);
    endtask

    task automatic t_reset();
        chk("R1 line", int'(line_o), 0);
        chk("R1 region", int'(region_o), 0);
        chk("R1 seq", int'(seq_sel_o), 0);
        chk("R1 sweep", int'(sweep_o), 0);
        chk("R1 start", int'(region_start_o), 0);
        chk("R1 sg", int'(sg_line_o), 1);
    endtask

    task automatic t_config();
        wr(0, 1, 2); wr(0, 2, 5); wr(0, 3, 6);
        for (int i = 0; i < NREG; i++) wr(1, i, i + 3);
        wr(2, 2, 1); wr(2, 5, 1);
        wr(3, 7, 4);
        chk("R10 xfer line off", int'(sg_line_o), 0);
        chk("R10 seq region0", int'(seq_sel_o), 3);
    endtask

    task automatic t_walk();
        step(1'b1, 1'b0);
        chk_all("walk vd");
        for (int k = 0; k < 9; k++) begin
            step(1'b0, 1'b1);
            chk_all("walk hd");
        end
        chk("R9 stall at unreached start", int'(region_o), 3);
    endtask

    task automatic t_vd_mid();
        step(1'b1, 1'b1);
        chk("R2 vd beats hd line", int'(line_o), 0);
        chk("R2 vd region", int'(region_o), 0);
        chk("R8 start on drop to 0", int'(region_start_o), 1);
        step(1'b1, 1'b0);
        chk("R8 no start when already 0", int'(region_start_o), 0);
    endtask

    task automatic t_full();
        for (int i = 4; i < NREG; i++) wr(0, i, i + 3);
        step(1'b1, 1'b0);
        for (int k = 0; k < 16; k++) begin
            step(1'b0, 1'b1);
            chk_all("full hd");
        end
        chk("R9 holds in last region", int'(region_o), 8);
    endtask

    task automatic t_sat();
        step(1'b1, 1'b0);
        for (int k = 0; k < 4100; k++) step(1'b0, 1'b1);
        chk("R3 saturate", int'(line_o), 4095);
        chk_all("sat");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin m_pos[i] = 0; m_seq[i] = 0; m_sw[i] = 0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_config();
        t_walk();
        t_vd_mid();
        t_full();
        t_sat();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule